// File: doc/BRIEF.md
# Pause-Width Keyed Bit Transmitter

This block sends a reader-to-tag command frame over one carrier-enable line. Each bit is coded by the width of the carrier-on period. Every bit opens with a fixed carrier-off gap. The carrier then comes back on, and the total bit length shows the bit's value: a long bit is a one and a short bit is a zero. The bit value used for this choice is the frame bit XORed with a keystream bit. The keystream bit comes from an outside generator, which this block steps once per bit through a single-cycle advance strobe.

All timing is counted in ticks. One tick is a fixed number of system clocks, 32 by default. The frame bits go out least significant bit first. After the last bit, one more carrier-off gap marks the end of the frame. At that point the tick prescaler restarts from zero and a done strobe is raised, so the receive path can time the tag's reply from that instant. A frame is launched with a start strobe, a frame word of up to 16 bits and a bit count.

Top module: `pause_keyed_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, carrier_o is 1 and neither ks_adv_o nor done_o is asserted.
- R2: Each bit begins with carrier_o at 0 for exactly PAUSE_TICKS*TICK_DIV clocks, counted from the clock edge that starts the bit.
- R3: The symbol of a bit is the frame bit XORed with ks_bit_i, sampled at the edge that starts the bit. The bit lasts ONE_TICKS*TICK_DIV clocks in total when the symbol is 1 and ZERO_TICKS*TICK_DIV clocks when it is 0, so the carrier-on part is the total minus the pause.
- R4: Frame bits are sent from frame_i[0] upward.
- R5: ks_adv_o is a one-cycle pulse, raised once per bit in the first carrier-on cycle after that bit's pause.
- R6: After the last bit, carrier_o is 0 for one more PAUSE_TICKS*TICK_DIV clocks and then returns to 1.
- R7: done_o is a one-cycle pulse in the first cycle after the trailing pause, when the carrier is on again. The tick prescaler restarts at that edge, so another frame may be started on the next cycle.
- R8: A start_i pulse while a frame is in progress is ignored, and the frame's timing is unchanged.
- R9: nbits_i gives the number of bits to send. A value of 0 is treated as 1, and a value above MAX_BITS is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches a frame when idle |
| frame_i | input | MAX_BITS | Frame word, sampled at start |
| nbits_i | input | $clog2(MAX_BITS+1) | Number of bits to send, sampled at start |
| ks_bit_i | input | 1 | Current keystream bit from the outside generator |
| carrier_o | output | 1 | Carrier enable, 1 = carrier on |
| ks_adv_o | output | 1 | One-cycle request to step the keystream |
| done_o | output | 1 | One-cycle end-of-frame strobe |

## Verification
The hardest case to reach is a bit whose symbol depends on the keystream value after several advances. A wrong sampling point or a missed advance only shows up once the generator has stepped. The bench therefore runs its own small keystream generator, driven by ks_adv_o, from a seed that it loads before each frame. It predicts every bit length from that seed and the frame word. To reach the ignored-start case, the bench pulses start_i in the middle of a frame and still checks every bit length of that frame. A seed of zero isolates the plain data order from the whitening.

// File: rtl/pkt_pkg.sv
// Shared types for the pause-keyed transmitter.
package pkt_pkg;
    // Frame sequencer states.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PAUSE = 2'd1,
        TX_MARK  = 2'd2,
        TX_TAIL  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/pkt_prescaler.sv
// Tick prescaler: asserts tick_o once every DIV clocks.
// Assumes DIV >= 2; restart_i returns the count to zero on the next edge.
module pkt_prescaler #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks, wrap at DIV-1, restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pkt_bit_timer.sv
// Elapsed-tick counter for the current bit or trailing pause.
// Assumes the caller clears it on every bit boundary; clear wins over tick.
module pkt_bit_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] elap_o
);
    // Count ticks since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) elap_o <= '0;
        else if (tick_i)     elap_o <= elap_o + 1'b1;
    end
endmodule

// File: rtl/pkt_shifter.sv
// Right-shifting frame register: bit 0 is the bit in flight, bit 1 the next.
// Assumes W >= 2; load_i has priority over shift_i.
module pkt_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         cur_o,
    output logic         nxt_o
);
    logic [W-1:0] sh_q;

    // Hold the frame word and move it down one bit per sent bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (load_i)  sh_q <= data_i;
        else if (shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
    end

    assign cur_o = sh_q[0];
    assign nxt_o = sh_q[1];
endmodule

// File: rtl/pause_keyed_tx.sv
// Pause-width keyed frame transmitter.
// Each bit is a carrier-off gap of PAUSE_TICKS followed by carrier-on until the
// bit reaches ONE_TICKS (symbol 1) or ZERO_TICKS (symbol 0); the symbol is the
// frame bit XOR the keystream bit. A trailing gap ends the frame, then done_o
// pulses and the tick prescaler restarts. Assumes PAUSE_TICKS < ZERO_TICKS,
// PAUSE_TICKS < ONE_TICKS, and an outside generator that steps on ks_adv_o
// before the next bit starts.
module pause_keyed_tx #(
    parameter int TICK_DIV    = 32,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90,
    parameter int MAX_BITS    = 16,
    localparam int NB_W       = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [NB_W-1:0]     nbits_i,
    input  logic                ks_bit_i,
    output logic                carrier_o,
    output logic                ks_adv_o,
    output logic                done_o
);
    import pkt_pkg::*;

    localparam int LEN_MAX = (ONE_TICKS > ZERO_TICKS) ? ONE_TICKS : ZERO_TICKS;
    localparam int EW      = $clog2(LEN_MAX + 1);
    localparam logic [EW-1:0] PAUSE_END = EW'(PAUSE_TICKS - 1);
    localparam logic [EW-1:0] ONE_END   = EW'(ONE_TICKS - 1);
    localparam logic [EW-1:0] ZERO_END  = EW'(ZERO_TICKS - 1);
    localparam logic [NB_W-1:0] NB_MAX  = NB_W'(MAX_BITS);

    tx_state_e       state_q;
    logic            sym_q;
    logic [NB_W-1:0] rem_q;
    logic            adv_q, done_q;

    logic            tick, restart, t_clr, sh_load, sh_shift;
    logic            cur_bit, nxt_bit;
    logic [EW-1:0]   elap;
    logic [NB_W-1:0] nb_eff;
    logic            pause_end, mark_end;

    pkt_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .tick_o(tick)
    );

    pkt_bit_timer #(.W(EW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(t_clr), .tick_i(tick), .elap_o(elap)
    );

    pkt_shifter #(.W(MAX_BITS)) u_sh (
        .clk(clk), .rst_n(rst_n), .load_i(sh_load), .data_i(frame_i),
        .shift_i(sh_shift), .cur_o(cur_bit), .nxt_o(nxt_bit)
    );

    // Clamp the requested bit count to 1..MAX_BITS.
    always_comb begin
        if (nbits_i == '0)         nb_eff = NB_W'(1);
        else if (nbits_i > NB_MAX) nb_eff = NB_MAX;
        else                       nb_eff = nbits_i;
    end

    // Timing comparisons against the elapsed-tick count.
    assign pause_end = tick && (elap == PAUSE_END);
    assign mark_end  = tick && (elap == (sym_q ? ONE_END : ZERO_END));

    // Strobes to the prescaler, timer and shifter, decoded from the state.
    always_comb begin
        sh_load  = (state_q == TX_IDLE) && start_i;
        sh_shift = (state_q == TX_MARK) && mark_end && (rem_q != '0);
        restart  = sh_load || ((state_q == TX_TAIL) && pause_end);
        t_clr    = sh_load || ((state_q == TX_MARK) && mark_end);
    end

    // Frame sequencer: pause, mark per bit, then trailing pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            sym_q   <= 1'b0;
            rem_q   <= '0;
            adv_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            adv_q  <= 1'b0;
            done_q <= 1'b0;
            unique case (state_q)
                TX_IDLE: if (start_i) begin
                    state_q <= TX_PAUSE;
                    sym_q   <= frame_i[0] ^ ks_bit_i;
                    rem_q   <= nb_eff - 1'b1;
                end
                TX_PAUSE: if (pause_end) begin
                    state_q <= TX_MARK;
                    adv_q   <= 1'b1;
                end
                TX_MARK: if (mark_end) begin
                    if (rem_q == '0) begin
                        state_q <= TX_TAIL;
                    end else begin
                        state_q <= TX_PAUSE;
                        sym_q   <= nxt_bit ^ ks_bit_i;
                        rem_q   <= rem_q - 1'b1;
                    end
                end
                TX_TAIL: if (pause_end) begin
                    state_q <= TX_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign carrier_o = (state_q != TX_PAUSE) && (state_q != TX_TAIL);
    assign ks_adv_o  = adv_q;
    assign done_o    = done_q;

    logic unused_cur;
    assign unused_cur = cur_bit;
endmodule

// File: rtl/pkt_tx_checker.sv
// Protocol checker for pause_keyed_tx, attached with bind.
// Assumes the gap length in clocks fits in 16 bits.
module pkt_tx_checker #(
    parameter int GAP_CLKS = 960
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              carrier_o,
    input logic              ks_adv_o,
    input logic              done_o,
    input pkt_pkg::tx_state_e state_q
);
    import pkt_pkg::*;

    logic [15:0] low_run;

    // Length of the current carrier-off run in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || carrier_o) low_run <= '0;
        else                     low_run <= low_run + 1'b1;
    end

    // R1: idle means carrier on.
    a_r1_idle_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> carrier_o);

    // R2 and R6: every carrier-off gap lasts exactly GAP_CLKS.
    a_r2_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_o && $past(!carrier_o)) |-> (low_run == 16'(GAP_CLKS)));

    // R5: advance pulse is in the first carrier-on cycle after a gap.
    a_r5_adv_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv_o |-> (carrier_o && $past(!carrier_o)));

    // R5: advance is a single-cycle pulse.
    a_r5_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv_o |=> !ks_adv_o);

    // R7: done is a single-cycle pulse after a gap.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (carrier_o && $past(!carrier_o) && state_q == TX_IDLE));

    // R8: a start during a pause does not end the frame.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_PAUSE && start_i) |=> (state_q != TX_IDLE));
endmodule

bind pause_keyed_tx pkt_tx_checker #(.GAP_CLKS(PAUSE_TICKS * TICK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .carrier_o(carrier_o),
    .ks_adv_o(ks_adv_o), .done_o(done_o), .state_q(state_q)
);

// File: tb/tb_pause_keyed_tx.sv
// Directed bench for pause_keyed_tx with shortened timing parameters.
module tb_pause_keyed_tx;
    localparam int D  = 4;
    localparam int P  = 3;
    localparam int T1 = 15;
    localparam int T0 = 9;
    localparam int MB = 16;
    localparam int NW = $clog2(MB + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [MB-1:0] frame = '0;
    logic [NW-1:0] nbits = '0;
    logic ks_bit, carrier, ks_adv, done;

    logic [7:0] ks_s = 8'h00, seed_v = 8'h00;
    logic load_seed = 1'b0;
    int adv_total = 0;
    int cycles = 0;
    bit timeout = 1'b0;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pause_keyed_tx #(.TICK_DIV(D), .PAUSE_TICKS(P), .ONE_TICKS(T1),
                     .ZERO_TICKS(T0), .MAX_BITS(MB)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .frame_i(frame),
        .nbits_i(nbits), .ks_bit_i(ks_bit), .carrier_o(carrier),
        .ks_adv_o(ks_adv), .done_o(done)
    );

    function automatic logic [7:0] ks_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic ks_at(input logic [7:0] seed, input int k);
        logic [7:0] s = seed;
        for (int i = 0; i < k; i++) s = ks_step(s);
        return s[0];
    endfunction

    // Bench keystream generator, stepped by the design's advance strobe.
    always @(posedge clk) begin
        if (load_seed)   ks_s <= seed_v;
        else if (ks_adv) ks_s <= ks_step(ks_s);
    end
    assign ks_bit = ks_s[0];

    // Advance pulse counter and watchdog, sampled away from the active edge.
    always @(negedge clk) begin
        if (ks_adv) adv_total++;
        cycles++;
        if (cycles > 150000) timeout = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends one frame and checks every gap, bit length, advance and done.
    task automatic run_frame(input logic [MB-1:0] data, input int nb_req,
                             input logic [7:0] seed, input bit poke, input string tag);
        int nexp, lo, hi, adv0, exp_hi;
        logic sym;
        nexp = (nb_req == 0) ? 1 : (nb_req > MB) ? MB : nb_req;
        @(negedge clk); load_seed = 1'b1; seed_v = seed;
        @(negedge clk); load_seed = 1'b0;
        frame = data; nbits = NW'(nb_req); start = 1'b1;
        adv0 = adv_total;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < nexp; k++) begin
            lo = 0; hi = 0;
            while (!carrier && !timeout) begin lo++; @(negedge clk); end
            while (carrier && !timeout) begin
                start = poke && (k == 1) && (hi == 2);
                hi++;
                @(negedge clk);
            end
            start = 1'b0;
            sym = data[k] ^ ks_at(seed, k);
            exp_hi = ((sym ? T1 : T0) - P) * D;
            check(lo == P * D, {tag, " R2 bit gap"}, lo, P * D);
            check(hi == exp_hi, {tag, " R3 R4 bit length"}, hi, exp_hi);
        end
        lo = 0;
        while (!carrier && !timeout) begin lo++; @(negedge clk); end
        check(lo == P * D, {tag, " R6 tail gap"}, lo, P * D);
        check(done == 1'b1, {tag, " R7 done after tail"}, done, 1);
        check(adv_total - adv0 == nexp, {tag, " R5 advance count"}, adv_total - adv0, nexp);
        @(negedge clk);
        check(done == 1'b0 && carrier == 1'b1, {tag, " R7 done single, R1 idle"}, done, 0);
    endtask

    task automatic t_reset();
        check(carrier == 1'b1, "R1 reset carrier", carrier, 1);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(ks_adv == 1'b0, "R1 reset advance", ks_adv, 0);
    endtask

    task automatic t_idle_hold();
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!carrier || done || ks_adv) bad++;
        end
        check(bad == 0, "R1 idle hold", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_hold();
        run_frame(16'h00B5, 8, 8'h00, 1'b0, "plain");
        run_frame(16'h0055, 7, 8'h5A, 1'b0, "whiten");
        run_frame(16'hA5C3, 16, 8'hC3, 1'b0, "full");
        run_frame(16'h0001, 1, 8'h00, 1'b0, "single");
        run_frame(16'hFFFF, 0, 8'h00, 1'b0, "R9 zero count");
        run_frame(16'h3C96, 20, 8'h81, 1'b0, "R9 over count");
        run_frame(16'h0F0F, 6, 8'h27, 1'b1, "R8 busy start");
        run_frame(16'h1234, 12, 8'h6B, 1'b0, "R7 back to back");
        t_idle_hold();
        if (timeout) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule